// File: doc/BRIEF.md
# Labelled-Jump Register Program Executor

A multi-cycle sequencer that runs a short register program out of an internal program store. Software, or an upstream controller, fills the store through a write port while the block is idle, optionally preloads some registers as inputs, and then pulses `start_i`. The block fetches and executes one instruction per cycle from address 0 upward. It produces no result port of its own: results stay in the register file and are read back through a combinational read port once `halted_o` rises.

A jump carries no address. It names a 4-bit label and a direction. An "up" jump targets the nearest labelled instruction at a lower address. A "down" jump targets the nearest labelled instruction at a higher address. The block finds the target by scanning the store one location per cycle. Execution halts on the CONTINUE that sits at the highest address holding a CONTINUE. If a jump's label cannot be found in its direction, or the store holds no CONTINUE at all, the block stops with `error_o` set.

Instruction word (19 bits, MSB first): opcode [18:15], register A [14:12], register B [11:9], jump target label [8:5], label-valid [4], own label [3:0]. The opcodes are:

| Code | Instruction |
|------|-------------|
| 0 | CONTINUE |
| 1 | INC A |
| 2 | DEC A |
| 3 | CLR A |
| 4 | A <- B |
| 5 | jump up if A is zero |
| 6 | jump down if A is zero |
| 7 | jump up always |
| 8 | jump down always |

Any other code is illegal and stops the block with an error.

Top module: `label_jump_exec`

## Requirements
- R1: After reset, `busy_o`, `halted_o` and `error_o` are 0 and every register reads 0.
- R2: A start pulse while idle clears every register that was not preloaded through the input port. Preloaded registers keep their value into the run.
- R3: INC (1) adds one modulo 2^16, CLR (3) writes zero, A <- B (4) copies register B into A, and DEC (2) subtracts one but saturates at zero. Instructions run in address order.
- R4: Opcodes 5 and 6 jump only when register A is zero. Otherwise execution falls through to the next address.
- R5: Opcodes 7 and 8 jump regardless of any register value.
- R6: An up jump (5, 7) lands on the nearest lower address whose label-valid bit is 1 and whose label equals the target field. A down jump (6, 8) lands on the nearest such higher address.
- R7: Each plain instruction takes one cycle. A taken jump takes one cycle plus one cycle per location scanned. For example, INC, INC, CONTINUE keeps `busy_o` high for 3 cycles, and a down jump to a label two slots away keeps it high for 4 cycles.
- R8: A CONTINUE below the highest-addressed CONTINUE only advances. Reaching the highest-addressed CONTINUE drops `busy_o` and raises `halted_o`.
- R9: A jump whose label does not exist in its search direction ends the run with `error_o` = 1, `halted_o` = 0 and `busy_o` = 0.
- R10: Input preloads and program writes are ignored while `busy_o` is 1. After the run, registers stay readable.
- R11: A start while the store holds no CONTINUE sets `error_o` without executing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Program store write enable |
| prog_addr_i | input | 5 | Program store write address |
| prog_data_i | input | 19 | Instruction word to store |
| in_we_i | input | 1 | Input register preload enable |
| in_sel_i | input | 3 | Register to preload |
| in_data_i | input | 16 | Preload value |
| start_i | input | 1 | Start pulse |
| rd_sel_i | input | 3 | Read-back register select |
| rd_data_o | output | 16 | Read-back register value |
| busy_o | output | 1 | Program running or label search in progress |
| halted_o | output | 1 | Last CONTINUE reached |
| error_o | output | 1 | Run stopped on an invalid jump, illegal opcode or missing CONTINUE |

## Verification
The bench uses the default parameters: 32 store locations and 16-bit registers. The 32-entry store lets every test rewrite the whole store with a non-CONTINUE filler, so a CONTINUE left by an earlier program cannot move the halt point. The 16-bit width means one preload of all ones followed by one INC is enough to reach the wrap. Programs with duplicated labels on both sides of a jump show that the nearest match wins in both directions.

// File: rtl/rje_pkg.sv
package rje_pkg;
  localparam int RIDX_W = 3;
  localparam int LBL_W  = 4;

  typedef enum logic [3:0] {
    OP_CONT  = 4'd0,
    OP_INC   = 4'd1,
    OP_DEC   = 4'd2,
    OP_CLR   = 4'd3,
    OP_MOV   = 4'd4,
    OP_JZ_UP = 4'd5,
    OP_JZ_DN = 4'd6,
    OP_J_UP  = 4'd7,
    OP_J_DN  = 4'd8
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [LBL_W-1:0]  tgt;
    logic              lv;
    logic [LBL_W-1:0]  lbl;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_SEARCH,
    ST_DONE,
    ST_ERR
  } st_e;
endpackage

// File: rtl/rje_prog_store.sv
module rje_prog_store
  import rje_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  instr_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output instr_t        rdata_o,
  output logic          last_vld_o,
  output logic [AW-1:0] last_pos_o
);
  instr_t           mem_q [DEPTH];
  logic [DEPTH-1:0] cont_q;  // marks slots holding CONTINUE, captured at write

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cont_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i]  <= wdata_i;
      cont_q[waddr_i] <= (wdata_i.op == OP_CONT);
    end
  end

  assign rdata_o = mem_q[raddr_i];

  always_comb begin
    last_vld_o = 1'b0;
    last_pos_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cont_q[i]) begin
        last_vld_o = 1'b1;
        last_pos_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/rje_reg_file.sv
module rje_reg_file #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 16,
  localparam int IW = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_we_i,
  input  logic [IW-1:0]    pre_sel_i,
  input  logic [REG_W-1:0] pre_data_i,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [IW-1:0]    ra_sel_i,
  output logic [REG_W-1:0] ra_o,
  input  logic [IW-1:0]    rb_sel_i,
  output logic [REG_W-1:0] rb_o,
  input  logic [IW-1:0]    rd_sel_i,
  output logic [REG_W-1:0] rd_o
);
  logic [REG_W-1:0]    regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] inmask_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g]   <= '0;
        inmask_q[g] <= 1'b0;
      end else if (wr_en_i && wr_sel_i == IW'(g)) begin
        regs_q[g] <= wr_data_i;
      end else if (pre_we_i && pre_sel_i == IW'(g)) begin
        regs_q[g]   <= pre_data_i;
        inmask_q[g] <= 1'b1;
      end else if (clr_i && !inmask_q[g]) begin
        regs_q[g] <= '0;
      end
    end
  end

  assign ra_o = regs_q[ra_sel_i];
  assign rb_o = regs_q[rb_sel_i];
  assign rd_o = regs_q[rd_sel_i];
endmodule

// File: rtl/label_jump_exec.sv
module label_jump_exec
  import rje_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int REG_W      = 16,
  localparam int AW       = $clog2(PROG_DEPTH),
  localparam int NUM_REGS = 2 ** RIDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [AW-1:0]      prog_addr_i,
  input  logic [INSTR_W-1:0] prog_data_i,
  input  logic               in_we_i,
  input  logic [RIDX_W-1:0]  in_sel_i,
  input  logic [REG_W-1:0]   in_data_i,
  input  logic               start_i,
  input  logic [RIDX_W-1:0]  rd_sel_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               busy_o,
  output logic               halted_o,
  output logic               error_o
);
  st_e              state_q, state_d;
  logic [AW-1:0]    pc_q, pc_d, ptr_q, ptr_d, last_pos, raddr;
  logic             up_q, up_d, last_vld;
  logic [LBL_W-1:0] tgt_q, tgt_d;
  instr_t           word;
  logic [REG_W-1:0] ra_val, rb_val, wr_data;
  logic             wr_en, run_start, jmp, dir_up;

  assign busy_o    = (state_q == ST_EXEC) || (state_q == ST_SEARCH);
  assign halted_o  = (state_q == ST_DONE);
  assign error_o   = (state_q == ST_ERR);
  assign run_start = start_i && !busy_o;
  assign raddr     = (state_q == ST_SEARCH) ? ptr_q : pc_q;

  rje_prog_store #(.DEPTH(PROG_DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (prog_we_i && !busy_o),
    .waddr_i    (prog_addr_i),
    .wdata_i    (instr_t'(prog_data_i)),
    .raddr_i    (raddr),
    .rdata_o    (word),
    .last_vld_o (last_vld),
    .last_pos_o (last_pos)
  );

  rje_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_we_i   (in_we_i && !busy_o),
    .pre_sel_i  (in_sel_i),
    .pre_data_i (in_data_i),
    .clr_i      (run_start),
    .wr_en_i    (wr_en),
    .wr_sel_i   (word.ra),
    .wr_data_i  (wr_data),
    .ra_sel_i   (word.ra),
    .ra_o       (ra_val),
    .rb_sel_i   (word.rb),
    .rb_o       (rb_val),
    .rd_sel_i   (rd_sel_i),
    .rd_o       (rd_data_o)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ptr_d   = ptr_q;
    up_d    = up_q;
    tgt_d   = tgt_q;
    wr_en   = 1'b0;
    wr_data = '0;
    jmp     = 1'b0;
    dir_up  = 1'b0;
    case (state_q)
      ST_EXEC: begin
        case (word.op)
          OP_CONT: begin
            if (pc_q == last_pos) state_d = ST_DONE;
            else pc_d = pc_q + AW'(1);
          end
          OP_INC, OP_DEC, OP_CLR, OP_MOV: begin
            wr_en = 1'b1;
            pc_d  = pc_q + AW'(1);
            case (word.op)
              OP_INC:  wr_data = ra_val + REG_W'(1);
              OP_DEC:  wr_data = (ra_val == '0) ? '0 : ra_val - REG_W'(1);
              OP_MOV:  wr_data = rb_val;
              default: wr_data = '0;
            endcase
          end
          OP_JZ_UP, OP_JZ_DN, OP_J_UP, OP_J_DN: begin
            jmp    = (word.op == OP_J_UP) || (word.op == OP_J_DN) || (ra_val == '0);
            dir_up = (word.op == OP_JZ_UP) || (word.op == OP_J_UP);
            if (!jmp) begin
              pc_d = pc_q + AW'(1);
            end else begin
              tgt_d = word.tgt;
              up_d  = dir_up;
              if (dir_up ? (pc_q == '0) : (pc_q == last_pos)) begin
                state_d = ST_ERR;
              end else begin
                ptr_d   = dir_up ? pc_q - AW'(1) : pc_q + AW'(1);
                state_d = ST_SEARCH;
              end
            end
          end
          default: state_d = ST_ERR;
        endcase
      end
      ST_SEARCH: begin
        if (word.lv && word.lbl == tgt_q) begin
          pc_d    = ptr_q;
          state_d = ST_EXEC;
        end else if (up_q ? (ptr_q == '0) : (ptr_q == last_pos)) begin
          state_d = ST_ERR;
        end else begin
          ptr_d = up_q ? ptr_q - AW'(1) : ptr_q + AW'(1);
        end
      end
      default: begin
        if (start_i) begin
          pc_d    = '0;
          state_d = last_vld ? ST_EXEC : ST_ERR;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ptr_q   <= '0;
      up_q    <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ptr_q   <= ptr_d;
      up_q    <= up_d;
      tgt_q   <= tgt_d;
    end
  end
endmodule

// File: rtl/rje_checker.sv
module rje_checker
  import rje_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          halted_o,
  input logic          error_o,
  input st_e           st_q,
  input logic [AW-1:0] ptr_q,
  input logic          up_q
);
  a_r8_halt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!busy_o && !error_o));

  a_r9_error_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!busy_o && !halted_o));

  a_r2_start_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o || error_o));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  a_r7_scan_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH && up_q) |=>
      (st_q != ST_SEARCH) || (ptr_q == $past(ptr_q) - AW'(1)));

  a_r7_scan_dn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH && !up_q) |=>
      (st_q != ST_SEARCH) || (ptr_q == $past(ptr_q) + AW'(1)));
endmodule

bind label_jump_exec rje_checker #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .halted_o (halted_o),
  .error_o  (error_o),
  .st_q     (state_q),
  .ptr_q    (ptr_q),
  .up_q     (up_q)
);

// File: tb/label_jump_exec_tb_top.sv
`timescale 1ns/1ps
module label_jump_exec_tb_top;
  import rje_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [4:0]  prog_addr_i = '0;
  logic [18:0] prog_data_i = '0;
  logic        in_we_i = 1'b0;
  logic [2:0]  in_sel_i = '0;
  logic [15:0] in_data_i = '0;
  logic        start_i = 1'b0;
  logic [2:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic        busy_o, halted_o, error_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  label_jump_exec dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i),
    .prog_data_i(prog_data_i), .in_we_i(in_we_i), .in_sel_i(in_sel_i),
    .in_data_i(in_data_i), .start_i(start_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .halted_o(halted_o), .error_o(error_o)
  );

  function automatic logic [18:0] mk(input logic [3:0] op, input int ra, input int rb,
                                     input int tgt, input int lv, input int lbl);
    logic [2:0] a = ra[2:0];
    logic [2:0] b = rb[2:0];
    logic [3:0] t = tgt[3:0];
    logic       v = lv[0];
    logic [3:0] l = lbl[3:0];
    return {op, a, b, t, v, l};
  endfunction

  localparam logic [18:0] FILL = mk(OP_CLR, 6, 0, 0, 0, 0);
  localparam int NV = 12;

  localparam logic [18:0] PROG [NV][8] = '{
    '{mk(OP_INC,0,0,0,0,0), mk(OP_INC,0,0,0,0,0), mk(OP_INC,0,0,0,0,0), mk(OP_DEC,0,0,0,0,0),
      mk(OP_CONT,0,0,0,0,0), mk(OP_CONT,0,0,0,0,0), FILL, FILL},
    '{mk(OP_DEC,1,0,0,0,0), mk(OP_DEC,1,0,0,0,0), mk(OP_INC,1,0,0,0,0), mk(OP_CONT,0,0,0,0,0),
      FILL, FILL, FILL, FILL},
    '{mk(OP_INC,2,0,0,0,0), mk(OP_INC,2,0,0,0,0), mk(OP_MOV,3,2,0,0,0), mk(OP_CLR,2,0,0,0,0),
      mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL},
    '{mk(OP_INC,4,0,0,0,0), mk(OP_J_DN,0,0,1,0,0), mk(OP_INC,4,0,0,0,0), mk(OP_INC,4,0,0,1,1),
      mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL},
    '{mk(OP_JZ_DN,5,0,2,0,0), mk(OP_INC,5,0,0,0,0), mk(OP_INC,6,0,0,1,2), mk(OP_CONT,0,0,0,0,0),
      FILL, FILL, FILL, FILL},
    '{mk(OP_INC,5,0,0,0,0), mk(OP_JZ_DN,5,0,2,0,0), mk(OP_INC,5,0,0,0,0), mk(OP_INC,6,0,0,1,2),
      mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL},
    '{mk(OP_INC,1,0,0,0,0), mk(OP_INC,1,0,0,0,0), mk(OP_INC,1,0,0,0,0), mk(OP_DEC,1,0,0,1,3),
      mk(OP_INC,2,0,0,0,0), mk(OP_JZ_DN,1,0,4,0,0), mk(OP_J_UP,0,0,3,0,0), mk(OP_CONT,0,0,0,1,4)},
    '{mk(OP_J_DN,0,0,5,0,0), mk(OP_INC,0,0,0,1,5), mk(OP_INC,0,0,0,1,5), mk(OP_INC,0,0,0,0,0),
      mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL},
    '{mk(OP_J_DN,0,0,7,0,0), mk(OP_INC,1,0,0,1,6), mk(OP_J_DN,0,0,8,1,6), mk(OP_J_UP,0,0,6,1,7),
      mk(OP_INC,1,0,0,0,0), mk(OP_CONT,0,0,0,1,8), FILL, FILL},
    '{mk(OP_J_DN,0,0,9,0,0), mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL, FILL, FILL, FILL},
    '{mk(OP_INC,0,0,0,0,0), mk(OP_J_UP,0,0,3,0,0), mk(OP_CONT,0,0,0,1,3), FILL,
      FILL, FILL, FILL, FILL},
    '{mk(OP_J_DN,0,0,2,0,0), mk(OP_INC,3,0,0,1,1), mk(OP_J_DN,0,0,3,0,0), mk(OP_JZ_UP,0,0,1,1,2),
      FILL, mk(OP_CONT,0,0,0,1,3), FILL, FILL}
  };
  localparam bit  EXP_ERR [NV] = '{0,0,0,0,0,0,0,0,0,1,1,0};
  localparam int  CHK_REG [NV] = '{0,1,3,4,5,5,2,0,1,0,0,3};
  localparam int  EXP_VAL [NV] = '{2,1,2,2,0,2,3,3,0,0,0,1};
  localparam string TAG   [NV] = '{"R3","R3","R3","R5","R4","R4","R6","R6","R6","R9","R9","R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_prog(input logic [18:0] w [8]);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk_i);
      prog_we_i   = 1'b1;
      prog_addr_i = 5'(a);
      prog_data_i = (a < 8) ? w[a] : FILL;
    end
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic preload(input int sel, input logic [15:0] val);
    @(negedge clk_i);
    in_we_i = 1'b1; in_sel_i = 3'(sel); in_data_i = val;
    @(negedge clk_i);
    in_we_i = 1'b0;
  endtask

  task automatic run(input bit poke, output int cyc);
    cyc = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    if (poke) begin
      in_we_i = 1'b1; in_sel_i = 3'd7; in_data_i = 16'd5;
    end
    while (busy_o && cyc < 2000) begin
      cyc++;
      @(negedge clk_i);
      in_we_i = 1'b0;
    end
    in_we_i = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [15:0] v);
    rd_sel_i = 3'(sel);
    #0.5;
    v = rd_data_o;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [18:0] w [8];
    int cyc;
    #12;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 halted", halted_o, 0);
    chk("R1 error", error_o, 0);
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk("R1 reg", v, 0);
    end

    // R11 start with empty store
    run(0, cyc);
    chk("R11 error", error_o, 1);
    chk("R11 busy", busy_o, 0);

    // table of programs
    for (int i = 0; i < NV; i++) begin
      w = PROG[i];
      load_prog(w);
      run(0, cyc);
      if (EXP_ERR[i]) begin
        chk({TAG[i], " error"}, error_o, 1);
        chk({TAG[i], " halted"}, halted_o, 0);
      end else begin
        chk({"R8 halted ", TAG[i]}, halted_o, 1);
        chk({TAG[i], " error"}, error_o, 0);
        rd(CHK_REG[i], v);
        chk({TAG[i], " reg"}, v, 32'(EXP_VAL[i]));
      end
    end

    // R7 straight-line timing
    w = '{mk(OP_INC,1,0,0,0,0), mk(OP_INC,1,0,0,0,0), mk(OP_CONT,0,0,0,0,0),
          FILL, FILL, FILL, FILL, FILL};
    load_prog(w);
    run(0, cyc);
    chk("R7 plain cycles", 32'(cyc), 3);

    // R7 search timing, R10 preload during run ignored
    w = '{mk(OP_J_DN,0,0,1,0,0), mk(OP_INC,1,0,0,0,0), mk(OP_CONT,0,0,0,1,1),
          FILL, FILL, FILL, FILL, FILL};
    load_prog(w);
    run(1, cyc);
    chk("R7 search cycles", 32'(cyc), 4);
    chk("R8 halted", halted_o, 1);
    rd(7, v);
    chk("R10 busy preload ignored", v, 0);
    rd(1, v);
    chk("R6 skipped slot", v, 0);

    // R2 / R3 inputs and wrap
    preload(0, 16'd7);
    preload(3, 16'hFFFF);
    w = '{mk(OP_INC,3,0,0,0,0), mk(OP_INC,0,0,0,0,0), mk(OP_INC,5,0,0,0,0),
          mk(OP_CONT,0,0,0,0,0), FILL, FILL, FILL, FILL};
    load_prog(w);
    run(0, cyc);
    rd(3, v); chk("R3 inc wrap", v, 0);
    rd(0, v); chk("R2 input kept", v, 8);
    rd(5, v); chk("R2 first run", v, 1);
    run(0, cyc);
    rd(0, v); chk("R2 input kept again", v, 9);
    rd(5, v); chk("R2 non-input cleared", v, 1);
    rd(3, v); chk("R2 input after wrap", v, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule